// File: doc/BRIEF.md
# Serial Flash Program/Erase Sequencer

This block sits on the host side of a 64-Mbit SPI NOR flash. It turns one user request into the full command sequence the flash needs. A request is one of four kinds: a page program, fed with 1 to 256 bytes from a byte stream; a 64 KiB sector erase; a whole-chip erase; or a status-register write. The block drives the serial clock, the chip select and MOSI, and samples MISO. When the request is finished it raises a one-cycle done pulse. With that pulse it also shows whether the request was refused or whether polling ran out of time.

Each operation follows the same steps. The block reads status until the busy bit reads clear. It then checks the write-protect state and sends write enable. It reads status again to confirm that the latch is set. It then sends the operation frame and polls status until the busy bit clears. The latch must have dropped at that point, or the operation counts as not executed. A program request that runs over a 256-byte page boundary is cut into several program operations, one per page, and each one repeats the full sequence.

Top module: `sflash_pe_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, req_ready is 1 and done, rejected and timeout_err are 0.
- R2: Frames use SPI mode 0. Chip select falls before the first clock, and the clock is low whenever chip select is high. MOSI changes only while the clock is low, and every byte goes out MSB first. Each clock half-period lasts clk_div+1 system cycles.
- R3: Each accepted operation runs these frames in order. First, read-status frames (opcode 0x05 plus one read byte) repeat until status bit 0 reads 0. Next comes a one-byte write-enable frame (0x06), then a read-status frame. Then the operation frame is sent, and read-status frames repeat until bit 0 reads 0.
- R4: Operation frames are: program 0x02, then a 24-bit address MSB first, then the data bytes; sector erase 0xD8 plus the address; chip erase 0xC7 alone; status write 0x01 plus one byte (req_stat). req_op encodes 0 program, 1 sector erase, 2 chip erase, 3 status write.
- R5: A program request is cut at every 256-byte boundary. Each piece is a separate program operation with its own full sequence. Data bytes are taken in stream order, one per dat_ready cycle, and only while chip select is low.
- R6: The protection code is status bits [4:2], and the sector number is address bits [22:16]. Code 0 protects nothing, codes 1 to 6 protect the top 2^code sectors, and code 7 protects all sectors. A program or sector erase aimed at a protected sector ends rejected after the first status read, and no write-enable or operation frame is sent.
- R7: A chip erase ends rejected after the first status read when the protection code is not zero.
- R8: A status write ends rejected after the first status read when status bit 7 is 1 and wp_n is low.
- R9: If status bit 1 (write-enable latch) reads 0 after write enable, the request ends rejected with no operation frame. If bit 1 still reads 1 once the busy bit has cleared after the operation, the request also ends rejected.
- R10: If POLL_LIMIT consecutive status reads in one polling phase all show bit 0 set, the request ends with done and timeout_err.
- R11: Between frames, chip select stays high for at least CS_GAP system cycles.
- R12: done is a one-cycle pulse. rejected and timeout_err are only ever 1 together with done. req_ready is 1 only when no request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| clk_div | input | DIV_W | serial clock half-period minus one, in system cycles |
| wp_n | input | 1 | write-protect pin level, low = asserted |
| req_valid | input | 1 | request strobe |
| req_ready | output | 1 | idle, accepting a request |
| req_op | input | 2 | request kind (R4 encoding) |
| req_addr | input | ADDR_W | target byte address |
| req_len | input | clog2(PAGE_BYTES+1) | program byte count, 1..PAGE_BYTES |
| req_stat | input | 8 | value for a status write |
| dat_valid | input | 1 | program data byte available |
| dat_byte | input | 8 | program data byte |
| dat_ready | output | 1 | data byte consumed this cycle |
| done | output | 1 | request finished (pulse) |
| rejected | output | 1 | request refused, valid with done |
| timeout_err | output | 1 | busy polling expired, valid with done |
| spi_sck | output | 1 | serial clock |
| spi_cs_n | output | 1 | chip select, active low |
| spi_mosi | output | 1 | serial data to flash |
| spi_miso | input | 1 | serial data from flash |

## Verification
The assertions take three things for granted about the inputs. First, a request is presented only while req_ready is high. Second, clk_div stays constant while a request is in progress. Third, req_len for a program is between 1 and PAGE_BYTES. The bench changes clk_div only between requests. It sends each request only after the previous done pulse, and it keeps every program length inside 1..256. The flash model in the bench answers status reads from its own status byte and can be set to refuse write enable, to ignore an operation, or to stay busy forever. This lets the refused and expired paths be reached without any illegal traffic on the bus.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
   typedef enum logic [1:0] {
      OP_PROG  = 2'd0,
      OP_SECT  = 2'd1,
      OP_CHIP  = 2'd2,
      OP_WSTAT = 2'd3
   } sfs_op_e;

   localparam logic [7:0] CMD_WREN  = 8'h06;
   localparam logic [7:0] CMD_RDST  = 8'h05;
   localparam logic [7:0] CMD_PROG  = 8'h02;
   localparam logic [7:0] CMD_SECT  = 8'hD8;
   localparam logic [7:0] CMD_CHIP  = 8'hC7;
   localparam logic [7:0] CMD_WSTAT = 8'h01;

   localparam int ST_BUSY = 0;
   localparam int ST_WEL  = 1;
   localparam int ST_BP0  = 2;
   localparam int ST_LOCK = 7;
endpackage

// File: rtl/sfs_spi_eng.sv
module sfs_spi_eng #(
   parameter int DIV_W  = 8,
   parameter int CS_GAP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] clk_div,
   input  logic             go,
   input  logic [7:0]       tx_byte,
   input  logic             last,
   input  logic             miso,
   output logic             done,
   output logic [7:0]       rx_byte,
   output logic             sck,
   output logic             cs_n,
   output logic             mosi
);
   localparam int GAP_W = $clog2(CS_GAP + 1);
   localparam int CNT_W = ((DIV_W > GAP_W) ? DIV_W : GAP_W) + 1;

   typedef enum logic [2:0] {E_IDLE, E_LOW, E_HIGH, E_HOLD, E_GAP} eng_st_e;

   eng_st_e          st;
   logic [CNT_W-1:0] cnt;
   logic [7:0]       sh;
   logic [2:0]       bitn;
   logic             last_q;
   logic             half_end;
   logic             gap_end;

   assign half_end = (cnt == CNT_W'(clk_div));
   assign gap_end  = (cnt == CNT_W'(CS_GAP - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= E_IDLE;
         cnt     <= '0;
         sh      <= '0;
         bitn    <= '0;
         last_q  <= 1'b0;
         sck     <= 1'b0;
         cs_n    <= 1'b1;
         mosi    <= 1'b0;
         rx_byte <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            E_IDLE: begin
               if (go) begin
                  sh     <= tx_byte;
                  mosi   <= tx_byte[7];
                  cs_n   <= 1'b0;
                  last_q <= last;
                  bitn   <= '0;
                  cnt    <= '0;
                  st     <= E_LOW;
               end
            end
            E_LOW: begin
               if (half_end) begin
                  sck     <= 1'b1;
                  rx_byte <= {rx_byte[6:0], miso};
                  cnt     <= '0;
                  st      <= E_HIGH;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            E_HIGH: begin
               if (half_end) begin
                  sck <= 1'b0;
                  cnt <= '0;
                  if (bitn == 3'd7) begin
                     if (last_q) begin
                        st <= E_HOLD;
                     end else begin
                        done <= 1'b1;
                        st   <= E_IDLE;
                     end
                  end else begin
                     bitn <= bitn + 1'b1;
                     sh   <= {sh[6:0], 1'b0};
                     mosi <= sh[6];
                     st   <= E_LOW;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            E_HOLD: begin
               if (half_end) begin
                  cs_n <= 1'b1;
                  cnt  <= '0;
                  st   <= E_GAP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (gap_end) begin
                  done <= 1'b1;
                  cnt  <= '0;
                  st   <= E_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/sfs_prot.sv
module sfs_prot #(
   parameter int SECT_W = 7
) (
   input  logic [2:0]        bp,
   input  logic [SECT_W-1:0] sector,
   output logic              hit
);
   localparam int NSECT = 1 << SECT_W;

   logic [SECT_W:0] n_prot;
   logic [SECT_W:0] first_prot;

   always_comb begin
      case (bp)
         3'd0:    n_prot = '0;
         3'd7:    n_prot = (SECT_W + 1)'(NSECT);
         default: n_prot = (SECT_W + 1)'(1) << bp;
      endcase
      first_prot = (SECT_W + 1)'(NSECT) - n_prot;
      hit        = (n_prot != '0) && ({1'b0, sector} >= first_prot);
   end
endmodule

// File: rtl/sfs_pager.sv
module sfs_pager #(
   parameter int ADDR_W     = 24,
   parameter int PAGE_BYTES = 256
) (
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [$clog2(PAGE_BYTES+1)-1:0]   remain,
   output logic [$clog2(PAGE_BYTES+1)-1:0]   chunk
);
   localparam int PG_W  = $clog2(PAGE_BYTES);
   localparam int LEN_W = $clog2(PAGE_BYTES + 1);

   logic [LEN_W-1:0] room;

   assign room  = LEN_W'(PAGE_BYTES) - LEN_W'(addr[PG_W-1:0]);
   assign chunk = (remain < room) ? remain : room;
endmodule

// File: rtl/sflash_pe_seq.sv
module sflash_pe_seq
   import sfs_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int PAGE_BYTES = 256,
   parameter int SECT_LSB   = 16,
   parameter int SECT_W     = 7,
   parameter int DIV_W      = 8,
   parameter int CS_GAP     = 4,
   parameter int POLL_LIMIT = 1000000
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [DIV_W-1:0]                  clk_div,
   input  logic                              wp_n,
   input  logic                              req_valid,
   output logic                              req_ready,
   input  logic [1:0]                        req_op,
   input  logic [ADDR_W-1:0]                 req_addr,
   input  logic [$clog2(PAGE_BYTES+1)-1:0]   req_len,
   input  logic [7:0]                        req_stat,
   input  logic                              dat_valid,
   input  logic [7:0]                        dat_byte,
   output logic                              dat_ready,
   output logic                              done,
   output logic                              rejected,
   output logic                              timeout_err,
   output logic                              spi_sck,
   output logic                              spi_cs_n,
   output logic                              spi_mosi,
   input  logic                              spi_miso
);
   localparam int LEN_W  = $clog2(PAGE_BYTES + 1);
   localparam int FIDX_W = $clog2(PAGE_BYTES + 5);
   localparam int PC_W   = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

   if (ADDR_W > 24 || SECT_LSB + SECT_W > ADDR_W) begin : g_bad_addr
      $error("sflash_pe_seq: address fields do not fit");
   end
   if (SECT_W < 6) begin : g_bad_sect
      $error("sflash_pe_seq: protection codes need at least 64 sectors");
   end
   if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 2) begin : g_bad_page
      $error("sflash_pe_seq: page size must be a power of two");
   end
   if (CS_GAP < 1) begin : g_bad_gap
      $error("sflash_pe_seq: CS_GAP must be at least one cycle");
   end

   typedef enum logic [2:0] {S_IDLE, S_CHK, S_WREN, S_WCHK, S_OP, S_POLL} seq_st_e;

   seq_st_e           st;
   sfs_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  rem_q;
   logic [7:0]        wdat_q;
   logic [FIDX_W-1:0] fidx;
   logic              pend;
   logic              lastp;

   logic              eng_go;
   logic              eng_last;
   logic              eng_done;
   logic [7:0]        eng_rx;
   logic [7:0]        tx;
   logic [FIDX_W-1:0] flen;
   logic              is_data;
   logic              frame_end;
   logic              busy_rd;
   logic              poll_clr;
   logic              tmo_hit;
   logic              req_fire;
   logic              prot_hit;
   logic              refuse;
   logic [LEN_W-1:0]  chunk;
   logic [23:0]       a24;

   sfs_spi_eng #(.DIV_W(DIV_W), .CS_GAP(CS_GAP)) u_eng (
      .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .go(eng_go), .tx_byte(tx),
      .last(eng_last), .miso(spi_miso), .done(eng_done), .rx_byte(eng_rx),
      .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi)
   );

   sfs_prot #(.SECT_W(SECT_W)) u_prot (
      .bp(eng_rx[ST_BP0 +: 3]), .sector(addr_q[SECT_LSB +: SECT_W]), .hit(prot_hit)
   );

   sfs_pager #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_pager (
      .addr(addr_q), .remain(rem_q), .chunk(chunk)
   );

   assign a24       = 24'(addr_q);
   assign req_ready = (st == S_IDLE);
   assign req_fire  = req_valid && req_ready;

   always_comb begin
      flen = FIDX_W'(2);
      tx   = (fidx == '0) ? CMD_RDST : 8'h00;
      case (st)
         S_WREN: begin
            flen = FIDX_W'(1);
            tx   = CMD_WREN;
         end
         S_OP: begin
            case (op_q)
               OP_PROG: flen = FIDX_W'(4) + FIDX_W'(chunk);
               OP_SECT: flen = FIDX_W'(4);
               OP_CHIP: flen = FIDX_W'(1);
               default: flen = FIDX_W'(2);
            endcase
            case (fidx)
               FIDX_W'(0): begin
                  case (op_q)
                     OP_PROG: tx = CMD_PROG;
                     OP_SECT: tx = CMD_SECT;
                     OP_CHIP: tx = CMD_CHIP;
                     default: tx = CMD_WSTAT;
                  endcase
               end
               FIDX_W'(1): tx = (op_q == OP_WSTAT) ? wdat_q : a24[23:16];
               FIDX_W'(2): tx = a24[15:8];
               FIDX_W'(3): tx = a24[7:0];
               default:    tx = dat_byte;
            endcase
         end
         default: ;
      endcase
   end

   assign is_data   = (st == S_OP) && (op_q == OP_PROG) && (fidx >= FIDX_W'(4));
   assign eng_go    = (st != S_IDLE) && !pend && (!is_data || dat_valid);
   assign eng_last  = (fidx == flen - 1'b1);
   assign dat_ready = eng_go && is_data;
   assign frame_end = eng_done && lastp;
   assign busy_rd   = frame_end && (st == S_CHK || st == S_POLL) && eng_rx[ST_BUSY];
   assign poll_clr  = req_fire || (frame_end && !busy_rd);

   if (POLL_LIMIT > 0) begin : g_tmo
      logic [PC_W-1:0] poll_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        poll_cnt <= '0;
         else if (poll_clr) poll_cnt <= '0;
         else if (busy_rd)  poll_cnt <= poll_cnt + 1'b1;
      end
      assign tmo_hit = (poll_cnt == PC_W'(POLL_LIMIT - 1));
   end else begin : g_no_tmo
      assign tmo_hit = 1'b0;
   end

   always_comb begin
      case (op_q)
         OP_PROG, OP_SECT: refuse = prot_hit;
         OP_CHIP:          refuse = (eng_rx[ST_BP0 +: 3] != 3'd0);
         default:          refuse = eng_rx[ST_LOCK] && !wp_n;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         op_q        <= OP_PROG;
         addr_q      <= '0;
         rem_q       <= '0;
         wdat_q      <= '0;
         fidx        <= '0;
         pend        <= 1'b0;
         lastp       <= 1'b0;
         done        <= 1'b0;
         rejected    <= 1'b0;
         timeout_err <= 1'b0;
      end else begin
         done        <= 1'b0;
         rejected    <= 1'b0;
         timeout_err <= 1'b0;
         if (eng_go) begin
            pend  <= 1'b1;
            lastp <= eng_last;
         end
         if (eng_done) begin
            pend <= 1'b0;
            fidx <= lastp ? '0 : fidx + 1'b1;
         end
         if (req_fire) begin
            op_q   <= sfs_op_e'(req_op);
            addr_q <= req_addr;
            rem_q  <= (sfs_op_e'(req_op) == OP_PROG) ? req_len : '0;
            wdat_q <= req_stat;
            fidx   <= '0;
            st     <= S_CHK;
         end
         if (frame_end) begin
            case (st)
               S_CHK: begin
                  if (eng_rx[ST_BUSY]) begin
                     if (tmo_hit) begin
                        st <= S_IDLE; done <= 1'b1; timeout_err <= 1'b1;
                     end
                  end else if (refuse) begin
                     st <= S_IDLE; done <= 1'b1; rejected <= 1'b1;
                  end else begin
                     st <= S_WREN;
                  end
               end
               S_WREN: st <= S_WCHK;
               S_WCHK: begin
                  if (!eng_rx[ST_WEL]) begin
                     st <= S_IDLE; done <= 1'b1; rejected <= 1'b1;
                  end else begin
                     st <= S_OP;
                  end
               end
               S_OP: begin
                  st <= S_POLL;
                  if (op_q == OP_PROG) begin
                     addr_q <= addr_q + ADDR_W'(chunk);
                     rem_q  <= rem_q - chunk;
                  end
               end
               S_POLL: begin
                  if (eng_rx[ST_BUSY]) begin
                     if (tmo_hit) begin
                        st <= S_IDLE; done <= 1'b1; timeout_err <= 1'b1;
                     end
                  end else if (eng_rx[ST_WEL]) begin
                     st <= S_IDLE; done <= 1'b1; rejected <= 1'b1;
                  end else if (rem_q != '0) begin
                     st <= S_CHK;
                  end else begin
                     st <= S_IDLE; done <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/sflash_pe_seq_chk.sv
module sflash_pe_seq_chk #(
   parameter int CS_GAP = 4
) (
   input logic clk,
   input logic rst_n,
   input logic spi_sck,
   input logic spi_cs_n,
   input logic spi_mosi,
   input logic done,
   input logic rejected,
   input logic timeout_err,
   input logic req_valid,
   input logic req_ready,
   input logic dat_valid,
   input logic dat_ready
);
   logic [15:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             gap <= 16'(CS_GAP);
      else if (!spi_cs_n)     gap <= '0;
      else if (gap != '1)     gap <= gap + 1'b1;
   end

   p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);
   p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
   p_dat_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dat_ready |-> (!spi_cs_n && dat_valid));
   p_cs_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (gap >= 16'(CS_GAP)));
   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_rej_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rejected |-> done);
   p_tmo_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> (done && !rejected));
   p_ready_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
endmodule

bind sflash_pe_seq sflash_pe_seq_chk #(.CS_GAP(CS_GAP)) u_chk (
   .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
   .spi_mosi(spi_mosi), .done(done), .rejected(rejected),
   .timeout_err(timeout_err), .req_valid(req_valid), .req_ready(req_ready),
   .dat_valid(dat_valid), .dat_ready(dat_ready)
);

// File: tb/tb_sflash_pe_seq.sv
module tb_sflash_pe_seq;
   localparam int CS_GAP = 3;
   localparam int POLL_LIMIT = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] clk_div = 8'd2;
   logic wp_n = 1'b1;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [1:0] req_op = 2'd0;
   logic [23:0] req_addr = '0;
   logic [8:0] req_len = '0;
   logic [7:0] req_stat = '0;
   logic dat_valid = 1'b1;
   logic [7:0] dat_byte;
   logic dat_ready;
   logic done, rejected, timeout_err;
   logic spi_sck, spi_cs_n, spi_mosi, spi_miso;

   always #2 clk = ~clk;

   sflash_pe_seq #(.CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)) dut (
      .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .wp_n(wp_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_len(req_len), .req_stat(req_stat),
      .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_ready(dat_ready),
      .done(done), .rejected(rejected), .timeout_err(timeout_err),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso)
   );

   int total = 0;
   int bad = 0;
   bit hung = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // data stream
   int dat_idx = 0;
   int exp_idx = 0;
   function automatic logic [7:0] dv(input int i);
      return 8'(i * 7 + 3);
   endfunction
   assign dat_byte = dv(dat_idx);
   always @(posedge clk) if (dat_ready) dat_idx <= dat_idx + 1;

   // behavioural flash model
   int log_q[$];
   int exp_q[$];
   logic [7:0] m_stat = 8'h00;
   int m_busy_left = 0;
   int m_busy_len = 2;
   bit m_refuse = 0, m_ignore = 0, m_stuck = 0;
   logic [7:0] m_sh = 0, m_out = 0;
   int m_bits = 0;
   logic [7:0] m_fr[$];
   logic miso_r = 1'b0;
   assign spi_miso = miso_r;

   task automatic begin_op();
      if (m_ignore) return;
      if (m_busy_len == 0) m_stat[1] = 1'b0;
      else begin
         m_stat[0] = 1'b1;
         m_busy_left = m_busy_len;
      end
   endtask

   task automatic frame_act();
      int n = m_fr.size();
      case (m_fr[0])
         8'h06: if (n == 1 && !m_refuse) m_stat[1] = 1'b1;
         8'h04: if (n == 1) m_stat[1] = 1'b0;
         8'h05: if (m_stat[0] && !m_stuck) begin
            if (m_busy_left > 0) m_busy_left--;
            if (m_busy_left == 0) m_stat[1:0] = 2'b00;
         end
         8'h02: if (n >= 5 && m_stat[1] && !m_stat[0]) begin_op();
         8'hD8: if (n == 4 && m_stat[1] && !m_stat[0]) begin_op();
         8'hC7: if (n == 1 && m_stat[1] && !m_stat[0]) begin_op();
         8'h01: if (n == 2 && m_stat[1] && !m_stat[0]) begin
            m_stat[7:2] = m_fr[1][7:2];
            begin_op();
         end
         default: ;
      endcase
   endtask

   always @(negedge spi_cs_n) begin
      m_bits = 0;
      m_fr.delete();
      m_out = 8'h00;
   end
   always @(posedge spi_sck) if (spi_cs_n === 1'b0) begin
      m_sh = {m_sh[6:0], spi_mosi};
      m_bits++;
      if (m_bits % 8 == 0) begin
         m_fr.push_back(m_sh);
         log_q.push_back(int'(m_sh));
         if (m_fr.size() == 1 && m_sh == 8'h05) m_out = m_stat;
      end
   end
   always @(negedge spi_sck) if (spi_cs_n === 1'b0) begin
      miso_r = m_out[7];
      m_out = {m_out[6:0], 1'b0};
   end
   always @(posedge spi_cs_n) begin
      log_q.push_back(-1);
      if (m_bits % 8 == 0 && m_fr.size() > 0) frame_act();
   end

   // port monitors
   int hi_cnt = 0, last_hi = 0, lo_cs = 0, min_gap = 1000, frames_seen = 0;
   int flag_viol = 0, done_prev = 0;
   always @(negedge clk) if (rst_n) begin
      if (spi_sck) hi_cnt++;
      else if (hi_cnt != 0) begin last_hi = hi_cnt; hi_cnt = 0; end
      if (spi_cs_n) lo_cs++;
      else begin
         if (lo_cs > 0 && frames_seen > 0 && lo_cs < min_gap) min_gap = lo_cs;
         if (lo_cs > 0) frames_seen++;
         lo_cs = 0;
      end
      if ((rejected || timeout_err) && !done) flag_viol++;
      if (done && done_prev != 0) flag_viol++;
      done_prev = done;
   end

   // expected-frame builders
   task automatic e_rdsr(); exp_q.push_back(5); exp_q.push_back(0); exp_q.push_back(-1); endtask
   task automatic e_wren(); exp_q.push_back(6); exp_q.push_back(-1); endtask
   task automatic e_addr(input int a);
      exp_q.push_back((a >> 16) & 255); exp_q.push_back((a >> 8) & 255); exp_q.push_back(a & 255);
   endtask
   task automatic e_polls(input int n); for (int i = 0; i < n; i++) e_rdsr(); endtask
   task automatic e_prog(input int a, input int n);
      e_rdsr(); e_wren(); e_rdsr();
      exp_q.push_back(2); e_addr(a);
      for (int i = 0; i < n; i++) begin exp_q.push_back(int'(dv(exp_idx))); exp_idx++; end
      exp_q.push_back(-1);
      e_polls(m_busy_len + 1);
   endtask
   task automatic e_sect(input int a);
      e_rdsr(); e_wren(); e_rdsr();
      exp_q.push_back(8'hD8); e_addr(a); exp_q.push_back(-1);
      e_polls(m_busy_len + 1);
   endtask
   task automatic e_simple(input int opc, input int dat, input bit has_dat);
      e_rdsr(); e_wren(); e_rdsr();
      exp_q.push_back(opc); if (has_dat) exp_q.push_back(dat); exp_q.push_back(-1);
      e_polls(m_busy_len + 1);
   endtask

   task automatic cmp(input string tag);
      int n = (log_q.size() > exp_q.size()) ? log_q.size() : exp_q.size();
      int at = -1;
      for (int i = 0; i < n; i++) begin
         if (i >= log_q.size() || i >= exp_q.size() || log_q[i] != exp_q[i]) begin at = i; break; end
      end
      if (at < 0) chk(1'b1, tag, 0, 0);
      else chk(1'b0, {tag, " frame stream"},
               (at < log_q.size()) ? log_q[at] : 999, (at < exp_q.size()) ? exp_q[at] : 999);
   endtask

   task automatic run(input int op, input int a, input int len, input int sv,
                      input bit er, input bit et, input string tag);
      int wd = 0;
      bit r = 0, t = 0;
      @(negedge clk);
      req_op = 2'(op); req_addr = 24'(a); req_len = 9'(len); req_stat = 8'(sv);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && wd < 60000) begin @(negedge clk); wd++; end
      if (!done) begin
         hung = 1;
         chk(1'b0, {tag, " watchdog"}, 0, 1);
      end else begin
         r = rejected; t = timeout_err;
      end
      repeat (2) @(negedge clk);
      chk(r == er && t == et, {tag, " outcome"}, {r, t}, {er, et});
      cmp(tag);
      log_q.delete(); exp_q.delete();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 bus idle", {spi_cs_n, spi_sck}, 2'b10);
      chk(req_ready == 1'b1 && done == 0 && rejected == 0 && timeout_err == 0,
          "R1 handshake idle", {req_ready, done, rejected, timeout_err}, 4'b1000);
      log_q.delete();

      // R3 R4 sector erase, divider 2
      e_sect(24'h123456);
      run(1, 24'h123456, 0, 0, 0, 0, "R3 R4 sector erase");
      chk(last_hi == 3, "R2 half period div2", last_hi, 3);

      clk_div = 8'd0;
      // R4 program inside one page
      e_prog(24'h000010, 4);
      run(0, 24'h000010, 4, 0, 0, 0, "R4 program");
      chk(last_hi == 1, "R2 half period div0", last_hi, 1);

      // R5 page split
      e_prog(24'h0100FC, 4); e_prog(24'h010100, 4);
      run(0, 24'h0100FC, 8, 0, 0, 0, "R5 split 4+4");
      e_prog(24'h020000, 256);
      run(0, 24'h020000, 256, 0, 0, 0, "R5 full page unsplit");
      e_prog(24'h020080, 128); e_prog(24'h020100, 128);
      run(0, 24'h020080, 256, 0, 0, 0, "R5 split 128+128");

      // R4 status write sets protect code 2 (top 4 sectors)
      e_simple(8'h01, 8'h08, 1);
      run(3, 0, 0, 8'h08, 0, 0, "R4 status write");
      chk(m_stat == 8'h08, "R4 status value", m_stat, 8'h08);

      // R6 protected sector 124 and boundary sector 123
      e_rdsr();
      run(0, 24'h7C0000, 1, 0, 1, 0, "R6 program protected");
      e_rdsr();
      run(1, 24'hFF0000, 0, 0, 1, 0, "R6 erase top sector, bit23 ignored");
      e_sect(24'h7B0000);
      run(1, 24'h7B0000, 0, 0, 0, 0, "R6 erase below range");

      // R7 chip erase with protection set
      e_rdsr();
      run(2, 0, 0, 0, 1, 0, "R7 chip erase refused");

      // R8 status lock with write-protect pin
      e_simple(8'h01, 8'h80, 1);
      run(3, 0, 0, 8'h80, 0, 0, "R8 set lock bit, pin high");
      wp_n = 1'b0;
      e_rdsr();
      run(3, 0, 0, 8'h00, 1, 0, "R8 locked write refused");
      chk(m_stat == 8'h80, "R8 status unchanged", m_stat, 8'h80);
      wp_n = 1'b1;
      e_simple(8'h01, 8'h00, 1);
      run(3, 0, 0, 8'h00, 0, 0, "R8 write allowed, pin high");
      e_simple(8'hC7, 0, 0);
      run(2, 0, 0, 0, 0, 0, "R7 chip erase allowed");

      // R9 latch not set
      m_refuse = 1;
      e_rdsr(); e_wren(); e_rdsr();
      run(1, 24'h050000, 0, 0, 1, 0, "R9 latch refused");
      m_refuse = 0;
      // R9 operation ignored, latch stays set
      m_ignore = 1;
      e_rdsr(); e_wren(); e_rdsr();
      exp_q.push_back(8'hD8); e_addr(24'h060000); exp_q.push_back(-1);
      e_rdsr();
      run(1, 24'h060000, 0, 0, 1, 0, "R9 op ignored");
      m_ignore = 0; m_stat = 8'h00;

      // R10 stuck busy
      m_stuck = 1;
      e_rdsr(); e_wren(); e_rdsr();
      exp_q.push_back(8'hD8); e_addr(24'h070000); exp_q.push_back(-1);
      e_polls(POLL_LIMIT);
      run(1, 24'h070000, 0, 0, 0, 1, "R10 timeout");
      m_stuck = 0; m_stat = 8'h00; m_busy_left = 0;

      // R3 busy at start, then one-byte pieces across a boundary
      m_stat = 8'h01; m_busy_left = 1;
      e_rdsr();
      e_prog(24'h0000FF, 1); e_prog(24'h000100, 1);
      run(0, 24'h0000FF, 2, 0, 0, 0, "R3 initial busy poll, R5 1+1");

      chk(min_gap >= CS_GAP, "R11 chip select gap", min_gap, CS_GAP);
      chk(flag_viol == 0, "R12 flag and pulse rules", flag_viol, 0);
      chk(req_ready == 1'b1, "R12 ready when idle", req_ready, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule